// File: doc/BRIEF.md
# Registered Four-Port Bus Exchanger

The exchanger links four 9-bit buses, named X0, X1, Y0 and Y1. Each bus is modelled as a separate input, a registered output and an output enable. A 5-bit flow code, taken on a clock edge, sets up to two directed transfers between the buses. Each transfer has one source and one destination. Every destination bus owns a data register. On data edges that register samples its source bus, and the destination bus then drives the register contents while its enable is high.

One clock serves both jobs, and the `data_phase` input chooses which one each edge does. With `data_phase` low, the edge stores a new flow code and the data registers are left alone. With `data_phase` high, the edge moves data along the routes of the code already held.

A separate `force_off` input blanks every enable at once, with no clock needed. Driving resumes only after an edge that stores a new flow code. In the code tables below, the leftmost digit is `flow_code[4]`. Port indices are X0=0, X1=1, Y0=2 and Y1=3.

Top module: `quad_port_xchg`

## Requirements
- R1: On a rising edge with `rst_n` high, `force_off` low and `data_phase` low, `flow_code` becomes the held flow state, and the enables after that edge follow it.
- R2: On a rising edge with `data_phase` high, each destination register of the held flow state loads the input of its source bus, and the held flow state does not change.
- R3: A data register changes only on a data edge that names its bus as a destination; an edge that loads a flow code leaves all data registers unchanged, and each `*_out` always shows its register.
- R4: While `force_off` is high, all four enables are low, without waiting for a clock edge.
- R5: While `force_off` is high, a clock edge does not change the held flow state; data edges still move data along the held routes.
- R6: After `force_off` falls, the enables stay low through data edges until an edge with `force_off` and `data_phase` both low loads a flow code.
- R7: Code 00000, and codes 00001 to 00111, drive no bus.
- R8: Codes 01000..01111 in order: X1->X0 with Y0->Y1; X1->X0; Y1->Y0; X1->X0 with Y1->Y0; X0->X1 with Y0->Y1; X0->X1; Y0->Y1; X0->X1 with Y1->Y0.
- R9: Codes 10000..10111 in order: X0->Y0 with Y1->X1; X0->Y0; X1->Y1; X0->Y0 with X1->Y1; Y0->X0 with X1->Y1; Y0->X0; Y1->X1; Y0->X0 with Y1->X1.
- R10: Codes 11000..11111 in order: Y1->X0 with X1->Y0; Y0->X1; Y1->X0; Y1->X0 with Y0->X1; X0->Y1 with Y0->X1; X0->Y1; X1->Y0; X0->Y1 with X1->Y0.
- R11: An enable is high only for a destination of the held flow state, so at most two enables are high at once.
- R12: A rising edge with `rst_n` low sets the held flow state to 00000 and clears all four data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_off | input | 1 | Asynchronous output blanking |
| data_phase | input | 1 | High: the edge moves data; low: the edge loads a flow code |
| flow_code | input | 5 | Flow code to store |
| x0_in | input | 9 | Bus X0 input |
| x0_out | output | 9 | Bus X0 data register |
| x0_oe | output | 1 | Bus X0 output enable |
| x1_in | input | 9 | Bus X1 input |
| x1_out | output | 9 | Bus X1 data register |
| x1_oe | output | 1 | Bus X1 output enable |
| y0_in | input | 9 | Bus Y0 input |
| y0_out | output | 9 | Bus Y0 data register |
| y0_oe | output | 1 | Bus Y0 output enable |
| y1_in | input | 9 | Bus Y1 input |
| y1_out | output | 9 | Bus Y1 data register |
| y1_oe | output | 1 | Bus Y1 output enable |

## Verification
The properties assume that `force_off`, `data_phase` and `flow_code` change only between clock edges. The exception is `force_off`, which may rise at any time. They also assume that reset is held over at least one edge before checking starts.

The stimulus changes every input just after a falling edge. It raises `force_off` mid-cycle on purpose to check the asynchronous blanking, and it holds reset low for three edges. Each of the 32 codes is loaded and then followed by a data edge with distinct inputs on all four buses, so that a wrong source can be seen at once.

// File: rtl/xchg_pkg.sv
// Package: shared types for the four-port exchanger.
// Holds the port indices, the hop record (one directed transfer) and the
// table that maps a 5-bit flow code to at most two hops.
package xchg_pkg;
    localparam int NPORT = 4;
    localparam int PW    = $clog2(NPORT);
    localparam int CW    = 5;
    localparam int HOPS  = 2;

    typedef logic [PW-1:0] port_t;

    localparam port_t PX0 = port_t'(0);
    localparam port_t PX1 = port_t'(1);
    localparam port_t PY0 = port_t'(2);
    localparam port_t PY1 = port_t'(3);

    typedef struct packed {
        logic  vld;
        port_t src;
        port_t dst;
    } hop_t;

    typedef hop_t [HOPS-1:0] hop_pair_t;

    // Build one valid hop from a source to a destination.
    function automatic hop_t mk(port_t s, port_t d);
        hop_t h;
        h.vld = 1'b1;
        h.src = s;
        h.dst = d;
        return h;
    endfunction

    // Flow code to hop pair; the unused and all-off codes give no hop.
    function automatic hop_pair_t hops_of(logic [CW-1:0] c);
        hop_pair_t h;
        h = '0;
        case (c)
            5'b01000: h = {mk(PX1, PX0), mk(PY0, PY1)};
            5'b01001: h[0] = mk(PX1, PX0);
            5'b01010: h[0] = mk(PY1, PY0);
            5'b01011: h = {mk(PX1, PX0), mk(PY1, PY0)};
            5'b01100: h = {mk(PX0, PX1), mk(PY0, PY1)};
            5'b01101: h[0] = mk(PX0, PX1);
            5'b01110: h[0] = mk(PY0, PY1);
            5'b01111: h = {mk(PX0, PX1), mk(PY1, PY0)};
            5'b10000: h = {mk(PX0, PY0), mk(PY1, PX1)};
            5'b10001: h[0] = mk(PX0, PY0);
            5'b10010: h[0] = mk(PX1, PY1);
            5'b10011: h = {mk(PX0, PY0), mk(PX1, PY1)};
            5'b10100: h = {mk(PY0, PX0), mk(PX1, PY1)};
            5'b10101: h[0] = mk(PY0, PX0);
            5'b10110: h[0] = mk(PY1, PX1);
            5'b10111: h = {mk(PY0, PX0), mk(PY1, PX1)};
            5'b11000: h = {mk(PY1, PX0), mk(PX1, PY0)};
            5'b11001: h[0] = mk(PY0, PX1);
            5'b11010: h[0] = mk(PY1, PX0);
            5'b11011: h = {mk(PY1, PX0), mk(PY0, PX1)};
            5'b11100: h = {mk(PX0, PY1), mk(PY0, PX1)};
            5'b11101: h[0] = mk(PX0, PY1);
            5'b11110: h[0] = mk(PX1, PY0);
            5'b11111: h = {mk(PX0, PY1), mk(PX1, PY0)};
            default:  h = '0;
        endcase
        return h;
    endfunction
endpackage

// File: rtl/xchg_flow_ctrl.sv
// Flow-state register and blanking flag.
// Stores the flow code on edges with force_off and data_phase both low.
// The mute flag is set asynchronously by force_off and cleared only by a
// flow-load edge. Assumes data_phase and code_in are steady around edges.
module xchg_flow_ctrl
    import xchg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_off,
    input  logic          data_phase,
    input  logic [CW-1:0] code_in,
    output logic [CW-1:0] code_q,
    output logic          muted
);
    // Hold the flow code; only a flow-load edge outside blanking changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (!force_off && !data_phase)
            code_q <= code_in;
    end

    // Mute on force_off at once; release on the next flow-load edge.
    always_ff @(posedge clk or posedge force_off) begin
        if (force_off)
            muted <= 1'b1;
        else if (!rst_n)
            muted <= 1'b0;
        else if (!data_phase)
            muted <= 1'b0;
    end
endmodule

// File: rtl/xchg_route_decode.sv
// Combinational route decode.
// Turns the held flow code into a destination mask and, per destination,
// the index of its source bus. Assumes a code never names one bus twice
// as a destination.
module xchg_route_decode
    import xchg_pkg::*;
(
    input  logic [CW-1:0]           code,
    output logic [NPORT-1:0]        dst_mask,
    output port_t [NPORT-1:0]       src_sel
);
    hop_pair_t hp;

    // Expand the hop pair into per-destination mask and source selects.
    always_comb begin
        hp       = hops_of(code);
        dst_mask = '0;
        src_sel  = '0;
        for (int k = 0; k < HOPS; k++) begin
            if (hp[k].vld) begin
                dst_mask[hp[k].dst] = 1'b1;
                src_sel[hp[k].dst]  = hp[k].src;
            end
        end
    end
endmodule

// File: rtl/xchg_lane.sv
// One destination data register.
// Loads the selected bus input when told to and otherwise holds.
// Assumes src_sel is valid whenever load is high.
module xchg_lane
    import xchg_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  port_t                     src_sel,
    input  logic [NPORT-1:0][DW-1:0]  bus_in,
    output logic [DW-1:0]             q
);
    // Capture the routed source on a data edge, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= bus_in[src_sel];
    end
endmodule

// File: rtl/quad_port_xchg.sv
// Top: registered four-port bus exchanger.
// A flow code chosen by data_phase=0 edges sets up to two transfers; edges
// with data_phase=1 move data into the destination registers. force_off
// blanks all enables asynchronously. Bus index order: X0, X1, Y0, Y1.
module quad_port_xchg
    import xchg_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_off,
    input  logic          data_phase,
    input  logic [CW-1:0] flow_code,
    input  logic [DW-1:0] x0_in,
    output logic [DW-1:0] x0_out,
    output logic          x0_oe,
    input  logic [DW-1:0] x1_in,
    output logic [DW-1:0] x1_out,
    output logic          x1_oe,
    input  logic [DW-1:0] y0_in,
    output logic [DW-1:0] y0_out,
    output logic          y0_oe,
    input  logic [DW-1:0] y1_in,
    output logic [DW-1:0] y1_out,
    output logic          y1_oe
);
    logic [NPORT-1:0][DW-1:0] in_vec;
    logic [NPORT-1:0][DW-1:0] q_vec;
    logic [NPORT-1:0]         oe_vec;
    logic [NPORT-1:0]         dst_mask;
    port_t [NPORT-1:0]        src_sel;
    logic [CW-1:0]            code_q;
    logic                     muted;

    assign in_vec = {y1_in, y0_in, x1_in, x0_in};

    xchg_flow_ctrl u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_off  (force_off),
        .data_phase (data_phase),
        .code_in    (flow_code),
        .code_q     (code_q),
        .muted      (muted)
    );

    xchg_route_decode u_dec (
        .code     (code_q),
        .dst_mask (dst_mask),
        .src_sel  (src_sel)
    );

    for (genvar d = 0; d < NPORT; d++) begin : g_lane
        xchg_lane #(.DW(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (data_phase & dst_mask[d]),
            .src_sel (src_sel[d]),
            .bus_in  (in_vec),
            .q       (q_vec[d])
        );
        // Enable a destination only when not blanked.
        assign oe_vec[d] = dst_mask[d] & ~muted & ~force_off;
    end

    assign x0_out = q_vec[0];
    assign x1_out = q_vec[1];
    assign y0_out = q_vec[2];
    assign y1_out = q_vec[3];
    assign x0_oe  = oe_vec[0];
    assign x1_oe  = oe_vec[1];
    assign y0_oe  = oe_vec[2];
    assign y1_oe  = oe_vec[3];
endmodule

// File: rtl/xchg_checker.sv
// Checker: temporal properties of the exchanger, bound to the top module.
// Assumes inputs other than force_off change only between clock edges.
module xchg_checker
    import xchg_pkg::*;
#(
    parameter int DW = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     force_off,
    input logic                     data_phase,
    input logic [CW-1:0]            flow_code,
    input logic [NPORT-1:0]         oe_vec,
    input logic [NPORT-1:0][DW-1:0] q_vec
);
    a_r4_force_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> (oe_vec == '0));

    a_r6_blank_until_reload: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (oe_vec == '0));

    a_r11_two_dest_max: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oe_vec) <= 2);

    a_r3_flow_edge_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        !data_phase |=> $stable(q_vec));

    a_r7_unused_codes_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_off && !data_phase && flow_code[4:3] == 2'b00) |=> (oe_vec == '0));

    a_r2_data_edge_keeps_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_off && data_phase) |=> (force_off || $stable(oe_vec)));
endmodule

bind quad_port_xchg xchg_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_off  (force_off),
    .data_phase (data_phase),
    .flow_code  (flow_code),
    .oe_vec     (oe_vec),
    .q_vec      (q_vec)
);

// File: tb/quad_port_xchg_test.sv
// Directed bench for quad_port_xchg; a spec-level model predicts all outputs.
module quad_port_xchg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       force_off = 1'b0;
    logic       data_phase = 1'b0;
    logic [4:0] flow_code = '0;
    logic [8:0] in_v [4];
    logic [8:0] out_w [4];
    logic [3:0] oe_w;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [4:0] m_code = '0;
    logic       m_muted = 1'b0;
    logic [8:0] m_q [4];

    always #10 clk = ~clk;

    quad_port_xchg uut (
        .clk(clk), .rst_n(rst_n), .force_off(force_off),
        .data_phase(data_phase), .flow_code(flow_code),
        .x0_in(in_v[0]), .x0_out(out_w[0]), .x0_oe(oe_w[0]),
        .x1_in(in_v[1]), .x1_out(out_w[1]), .x1_oe(oe_w[1]),
        .y0_in(in_v[2]), .y0_out(out_w[2]), .y0_oe(oe_w[2]),
        .y1_in(in_v[3]), .y1_out(out_w[3]), .y1_oe(oe_w[3])
    );

    // Source bus for destination d under code c, or -1 (index X0,X1,Y0,Y1).
    function automatic int src_for(logic [4:0] c, int d);
        int s[4];
        s = '{-1, -1, -1, -1};
        case (c)
            5'b01000: begin s[0] = 1; s[3] = 2; end
            5'b01001: s[0] = 1;
            5'b01010: s[2] = 3;
            5'b01011: begin s[0] = 1; s[2] = 3; end
            5'b01100: begin s[1] = 0; s[3] = 2; end
            5'b01101: s[1] = 0;
            5'b01110: s[3] = 2;
            5'b01111: begin s[1] = 0; s[2] = 3; end
            5'b10000: begin s[2] = 0; s[1] = 3; end
            5'b10001: s[2] = 0;
            5'b10010: s[3] = 1;
            5'b10011: begin s[2] = 0; s[3] = 1; end
            5'b10100: begin s[0] = 2; s[3] = 1; end
            5'b10101: s[0] = 2;
            5'b10110: s[1] = 3;
            5'b10111: begin s[0] = 2; s[1] = 3; end
            5'b11000: begin s[0] = 3; s[2] = 1; end
            5'b11001: s[1] = 2;
            5'b11010: s[0] = 3;
            5'b11011: begin s[0] = 3; s[1] = 2; end
            5'b11100: begin s[3] = 0; s[1] = 2; end
            5'b11101: s[3] = 0;
            5'b11110: s[2] = 1;
            5'b11111: begin s[3] = 0; s[2] = 1; end
            default: ;
        endcase
        return s[d];
    endfunction

    function automatic logic [3:0] exp_oe();
        logic [3:0] m;
        for (int d = 0; d < 4; d++)
            m[d] = (src_for(m_code, d) >= 0) && !m_muted && !force_off;
        return m;
    endfunction

    task automatic check_oe(string req);
        logic [3:0] e;
        e = exp_oe();
        n_chk++;
        if (oe_w !== e) begin
            n_fail++;
            $display("FAIL %s: oe act=%b exp=%b", req, oe_w, e);
        end
    endtask

    task automatic check_data(string req);
        n_chk++;
        if (out_w[0] !== m_q[0] || out_w[1] !== m_q[1] ||
            out_w[2] !== m_q[2] || out_w[3] !== m_q[3]) begin
            n_fail++;
            $display("FAIL %s: out act=%h %h %h %h exp=%h %h %h %h", req,
                     out_w[0], out_w[1], out_w[2], out_w[3],
                     m_q[0], m_q[1], m_q[2], m_q[3]);
        end
    endtask

    task automatic set_inputs(int seed);
        for (int p = 0; p < 4; p++)
            in_v[p] = 9'((seed * 37 + p * 101 + 3) & 511);
    endtask

    // One clock edge with the given controls; model updated after the edge.
    task automatic drive_edge(logic fo, logic dp, logic [4:0] code);
        int s;
        force_off = fo;
        data_phase = dp;
        flow_code = code;
        if (fo) m_muted = 1'b1;
        @(posedge clk);
        if (dp) begin
            for (int d = 0; d < 4; d++) begin
                s = src_for(m_code, d);
                if (s >= 0) m_q[d] = in_v[s];
            end
        end else if (!fo) begin
            m_code = code;
            m_muted = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();   // R12
        set_inputs(7);
        rst_n = 1'b0;
        data_phase = 1'b1;
        flow_code = 5'b01000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_code = '0;
        m_muted = 1'b0;
        for (int d = 0; d < 4; d++) m_q[d] = '0;
        check_oe("R12");
        check_data("R12");
    endtask

    task automatic t_sweep();   // R1 R2 R7 R8 R9 R10 R11
        string grp;
        for (int c = 0; c < 32; c++) begin
            grp = (c < 8) ? "R1/R7" : (c < 16) ? "R1/R8" : (c < 24) ? "R1/R9" : "R1/R10";
            set_inputs(c);
            drive_edge(1'b0, 1'b0, 5'(c));
            check_oe({grp, "/R11"});
            check_data("R3");
            set_inputs(c + 50);
            drive_edge(1'b0, 1'b1, 5'(c));
            check_data({"R2/", grp});
            check_oe("R2");
        end
    endtask

    task automatic t_flow_keeps_data();   // R3
        set_inputs(90);
        drive_edge(1'b0, 1'b0, 5'b01001);
        drive_edge(1'b0, 1'b1, 5'b00000);
        check_data("R3");
        set_inputs(91);
        drive_edge(1'b0, 1'b0, 5'b10101);
        check_data("R3");
        check_oe("R3");
        set_inputs(92);
        drive_edge(1'b0, 1'b0, 5'b10101);
        check_data("R3");
    endtask

    task automatic t_force_off();   // R4 R5 R6
        set_inputs(120);
        drive_edge(1'b0, 1'b0, 5'b01001);
        drive_edge(1'b0, 1'b1, 5'b00000);
        check_oe("R4");
        #3;
        force_off = 1'b1;
        m_muted = 1'b1;
        #2;
        check_oe("R4");
        @(negedge clk);
        drive_edge(1'b1, 1'b0, 5'b10010);
        check_oe("R5");
        set_inputs(121);
        drive_edge(1'b1, 1'b1, 5'b10010);
        check_data("R5");
        set_inputs(122);
        drive_edge(1'b0, 1'b1, 5'b10010);
        check_oe("R6");
        check_data("R6");
        drive_edge(1'b0, 1'b0, 5'b10010);
        check_oe("R6");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        set_inputs(0);
        for (int d = 0; d < 4; d++) m_q[d] = '0;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_flow_keeps_data();
        t_force_off();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule